// File: doc/BRIEF.md
# Difference-of-Means Power Trace Sorter

This block runs a difference-of-means side-channel test for one 6-bit subkey guess against the last round of a DES-style cipher. A trace enters as a sample stream. The known 32-bit right half of the ciphertext and the test settings sit on side inputs, and the block captures them together with the first sample of the trace. From the ciphertext bits and the guess, the block looks up a 4-bit selection value. It holds the trace in a staging buffer until its last sample arrives. It then either adds the trace, sample by sample, into one of two per-sample sum banks, or drops it.

When a readout is requested, the block streams one bias value for each sample index. The value is the difference of the two bin means, scaled by the product of the two trace counts so that no divider is needed. For the correct guess, this signal peaks at the sample where the hardware under test computed the selection value.

Both streams use valid/ready. The input stream is back-pressured: `s_ready` drops while a kept trace is merged into a bin and while a readout is in progress. The output stream holds its value until the consumer takes it, and the consumer may stall it for any number of cycles.

Top module: `dpa_partition_acc`

## Requirements
- R1: After reset, or in the cycle after `clr_run` is high, both trace counts are zero, no readout is active, and every subsequent bias value reads zero until traces are kept.
- R2: The selection value is entry `idx` of the first DES S-box, where `idx = key_guess XOR {ct_r[0], ct_r[31:27]}`. Here `ct_r[31]` is the most significant bit. `idx[5]` and `idx[0]` form the row (`idx[5]` is the row MSB), and `idx[4:1]` form the column.
- R3: In single-bit mode (`sel_mode` = 0), a trace whose selection bit `bit_pick` (0 is the LSB) is 1 goes to bin 1, and any other trace goes to bin 0. The count of that bin rises by one.
- R4: In nibble mode (`sel_mode` = 1), a trace goes to bin 1 only when the selection value is 4'hF, and to bin 0 only when it is 4'h0. Any other trace changes no count and no sum.
- R5: Readout value k equals sum1[k]*cnt0 - sum0[k]*cnt1. Here sumb[k] is the total of sample k over all traces kept in bin b, and cntb is the count of bin b.
- R6: Every bias value is zero while either count is zero.
- R7: A trace whose final beat is not beat number TRACE_LEN raises `len_err` for exactly the cycle after that beat, and changes no count and no sum.
- R8: `s_ready` is low from the cycle after the accepted final beat of a correct-length trace until the trace has been judged and merged. It is also low for the whole readout.
- R9: A `rd_start` pulse seen while no trace is in progress streams TRACE_LEN values. `m_last` is set on the final value. `m_valid`, `m_data` and `m_last` hold steady while `m_ready` is low.
- R10: `ct_r`, `key_guess`, `sel_mode` and `bit_pick` are captured on the first beat of a trace, so later changes during that trace have no effect on where it is sorted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr_run | input | 1 | Synchronous clear of both bins, counts and sequencing |
| ct_r | input | 32 | Ciphertext right half, captured on the first beat |
| key_guess | input | 6 | Subkey guess for the chosen S-box |
| sel_mode | input | 1 | 0 single-bit sort, 1 all-ones/all-zeros sort |
| bit_pick | input | 2 | Selection bit used in single-bit mode |
| s_valid | input | 1 | Sample beat valid |
| s_ready | output | 1 | Sample beat accepted when high with s_valid |
| s_data | input | SAMPLE_W | Signed power sample |
| s_last | input | 1 | Final sample of the trace |
| rd_start | input | 1 | Pulse to begin the bias readout |
| m_valid | output | 1 | Bias value valid |
| m_ready | input | 1 | Consumer takes the bias value |
| m_data | output | BIAS_W | Signed scaled bias value |
| m_last | output | 1 | Final bias value of the readout |
| cnt0 | output | CNT_W | Traces kept in bin 0 |
| cnt1 | output | CNT_W | Traces kept in bin 1 |
| len_err | output | 1 | One-cycle pulse on a wrong-length trace |

## Verification
The hardest case to reach from the ports is nibble mode. There, only ciphertexts whose S-box lookup gives exactly 0 or 15 touch the bins, so most traces must be shown to leave both sums and counts untouched. The stimulus sweeps many ciphertext values against a fixed guess. The bench predicts which ones land in each bin or are dropped, then confirms this through the counts and a full readout. The readout itself runs under a stall pattern on `m_ready`, so that the hold behaviour is exercised on every value. Short and overlong traces, and a ciphertext changed after the first beat, are mixed into the same run.

// File: rtl/dpa_pkg.sv
package dpa_pkg;

  typedef enum logic {
    SEL_ONE_BIT = 1'b0,
    SEL_NIBBLE  = 1'b1
  } sel_mode_e;

  typedef enum logic [1:0] {
    ST_CAP,
    ST_JUDGE,
    ST_COMMIT,
    ST_READ
  } acc_state_e;

  // First DES substitution box, one 64-bit word per row, column 0 in the top nibble.
  function automatic logic [3:0] sbox_first(input logic [5:0] idx);
    logic [63:0] row_word;
    logic [1:0]  row;
    logic [3:0]  col;
    row = {idx[5], idx[0]};
    col = idx[4:1];
    case (row)
      2'd0:    row_word = 64'hE4D12FB83A6C5907;
      2'd1:    row_word = 64'h0F74E2D1A6CB9538;
      2'd2:    row_word = 64'h41E8D62BFC973A50;
      default: row_word = 64'hFC8249175B3EA06D;
    endcase
    return row_word[(4'd15 - col) * 4 +: 4];
  endfunction

endpackage

// File: rtl/dpa_select.sv
module dpa_select
  import dpa_pkg::*;
(
  input  logic [31:0] ct_r,
  input  logic [5:0]  guess,
  input  sel_mode_e   mode,
  input  logic [1:0]  bit_pick,
  output logic        keep,
  output logic        to_bin1
);

  logic [5:0] sbox_idx;
  logic [3:0] sel_val;

  // Expansion taps feeding the first S-box: last bit of the half, then its top five.
  assign sbox_idx = guess ^ {ct_r[0], ct_r[31:27]};
  assign sel_val  = sbox_first(sbox_idx);

  always_comb begin
    if (mode == SEL_ONE_BIT) begin
      keep    = 1'b1;
      to_bin1 = sel_val[bit_pick];
    end else begin
      keep    = (sel_val == 4'hF) || (sel_val == 4'h0);
      to_bin1 = (sel_val == 4'hF);
    end
  end

endmodule

// File: rtl/dpa_bins.sv
module dpa_bins #(
  parameter int TRACE_LEN = 16,
  parameter int SAMPLE_W  = 8,
  parameter int SUM_W     = 24,
  parameter int CNT_W     = 17,
  localparam int AW       = (TRACE_LEN > 1) ? $clog2(TRACE_LEN) : 1
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr,
  input  logic                       add_en,
  input  logic                       add_bin,
  input  logic [AW-1:0]              add_idx,
  input  logic signed [SAMPLE_W-1:0] add_val,
  input  logic                       cnt_inc,
  input  logic [AW-1:0]              rd_idx,
  output logic signed [SUM_W-1:0]    rd_sum0,
  output logic signed [SUM_W-1:0]    rd_sum1,
  output logic [CNT_W-1:0]           cnt0,
  output logic [CNT_W-1:0]           cnt1
);

  logic signed [SUM_W-1:0] rd_sum_arr [2];
  logic [CNT_W-1:0]        cnt_arr    [2];
  logic signed [SUM_W-1:0] add_ext;

  assign add_ext = SUM_W'(add_val);

  for (genvar b = 0; b < 2; b++) begin : g_bin
    logic signed [SUM_W-1:0] sum_mem [TRACE_LEN];
    logic [CNT_W-1:0]        count;
    logic                    hit;

    assign hit = (add_bin == 1'(b));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < TRACE_LEN; i++) sum_mem[i] <= '0;
        count <= '0;
      end else if (clr) begin
        for (int i = 0; i < TRACE_LEN; i++) sum_mem[i] <= '0;
        count <= '0;
      end else begin
        if (add_en && hit) sum_mem[add_idx] <= sum_mem[add_idx] + add_ext;
        if (cnt_inc && hit) count <= count + CNT_W'(1);
      end
    end

    assign rd_sum_arr[b] = sum_mem[rd_idx];
    assign cnt_arr[b]    = count;
  end

  assign rd_sum0 = rd_sum_arr[0];
  assign rd_sum1 = rd_sum_arr[1];
  assign cnt0    = cnt_arr[0];
  assign cnt1    = cnt_arr[1];

endmodule

// File: rtl/dpa_bias.sv
module dpa_bias #(
  parameter int SUM_W  = 24,
  parameter int CNT_W  = 17,
  parameter int BIAS_W = 43
) (
  input  logic signed [SUM_W-1:0]  sum0,
  input  logic signed [SUM_W-1:0]  sum1,
  input  logic [CNT_W-1:0]         cnt0,
  input  logic [CNT_W-1:0]         cnt1,
  output logic signed [BIAS_W-1:0] bias
);

  logic signed [BIAS_W-1:0] s0x, s1x, c0x, c1x, prod1, prod0;

  assign s0x   = BIAS_W'(sum0);
  assign s1x   = BIAS_W'(sum1);
  assign c0x   = BIAS_W'(cnt0);
  assign c1x   = BIAS_W'(cnt1);
  assign prod1 = s1x * c0x;
  assign prod0 = s0x * c1x;
  assign bias  = ((cnt0 == '0) || (cnt1 == '0)) ? '0 : (prod1 - prod0);

endmodule

// File: rtl/dpa_partition_acc.sv
module dpa_partition_acc
  import dpa_pkg::*;
#(
  parameter int TRACE_LEN      = 16,
  parameter int SAMPLE_W       = 8,
  parameter int TRACE_CAP_LOG2 = 16,
  localparam int CNT_W         = TRACE_CAP_LOG2 + 1,
  localparam int SUM_W         = SAMPLE_W + TRACE_CAP_LOG2,
  localparam int BIAS_W        = SUM_W + CNT_W + 2
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       clr_run,
  input  logic [31:0]                ct_r,
  input  logic [5:0]                 key_guess,
  input  logic                       sel_mode,
  input  logic [1:0]                 bit_pick,
  input  logic                       s_valid,
  output logic                       s_ready,
  input  logic signed [SAMPLE_W-1:0] s_data,
  input  logic                       s_last,
  input  logic                       rd_start,
  output logic                       m_valid,
  input  logic                       m_ready,
  output logic signed [BIAS_W-1:0]   m_data,
  output logic                       m_last,
  output logic [CNT_W-1:0]           cnt0,
  output logic [CNT_W-1:0]           cnt1,
  output logic                       len_err
);

  localparam int AW = (TRACE_LEN > 1) ? $clog2(TRACE_LEN) : 1;
  localparam int IW = $clog2(TRACE_LEN + 1);
  localparam logic [AW-1:0] LAST_IDX  = AW'(TRACE_LEN - 1);
  localparam logic [IW-1:0] BEAT_LAST = IW'(TRACE_LEN - 1);
  localparam logic [IW-1:0] BEAT_FULL = IW'(TRACE_LEN);

  acc_state_e              state;
  logic [IW-1:0]           beat_idx;
  logic [AW-1:0]           c_idx, r_idx;
  logic                    tgt_bin;
  logic [31:0]             lat_ct;
  logic [5:0]              lat_guess;
  sel_mode_e               lat_mode;
  logic [1:0]              lat_pick;
  logic                    keep, to_bin1;
  logic signed [SAMPLE_W-1:0] stage_mem [TRACE_LEN];
  logic signed [SUM_W-1:0] rd_sum0, rd_sum1;
  logic                    beat_fire;

  assign s_ready   = (state == ST_CAP);
  assign beat_fire = s_valid && s_ready;
  assign m_valid   = (state == ST_READ);
  assign m_last    = m_valid && (r_idx == LAST_IDX);

  dpa_select u_sel (
    .ct_r     (lat_ct),
    .guess    (lat_guess),
    .mode     (lat_mode),
    .bit_pick (lat_pick),
    .keep     (keep),
    .to_bin1  (to_bin1)
  );

  // Staging buffer: a trace is only merged once its length is known good.
  always_ff @(posedge clk) begin
    if (beat_fire && (beat_idx < BEAT_FULL)) stage_mem[beat_idx[AW-1:0]] <= s_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_CAP;
      beat_idx  <= '0;
      c_idx     <= '0;
      r_idx     <= '0;
      tgt_bin   <= 1'b0;
      lat_ct    <= '0;
      lat_guess <= '0;
      lat_mode  <= SEL_ONE_BIT;
      lat_pick  <= '0;
      len_err   <= 1'b0;
    end else if (clr_run) begin
      state    <= ST_CAP;
      beat_idx <= '0;
      c_idx    <= '0;
      r_idx    <= '0;
      len_err  <= 1'b0;
    end else begin
      len_err <= 1'b0;
      case (state)
        ST_CAP: begin
          if (beat_fire) begin
            if (beat_idx == '0) begin
              lat_ct    <= ct_r;
              lat_guess <= key_guess;
              lat_mode  <= sel_mode_e'(sel_mode);
              lat_pick  <= bit_pick;
            end
            if (s_last) begin
              beat_idx <= '0;
              if (beat_idx == BEAT_LAST) state <= ST_JUDGE;
              else len_err <= 1'b1;
            end else if (beat_idx != BEAT_FULL) begin
              beat_idx <= beat_idx + IW'(1);
            end
          end else if (rd_start && (beat_idx == '0)) begin
            state <= ST_READ;
            r_idx <= '0;
          end
        end
        ST_JUDGE: begin
          if (keep) begin
            tgt_bin <= to_bin1;
            c_idx   <= '0;
            state   <= ST_COMMIT;
          end else begin
            state <= ST_CAP;
          end
        end
        ST_COMMIT: begin
          c_idx <= c_idx + AW'(1);
          if (c_idx == LAST_IDX) state <= ST_CAP;
        end
        default: begin
          if (m_ready) begin
            if (r_idx == LAST_IDX) state <= ST_CAP;
            else r_idx <= r_idx + AW'(1);
          end
        end
      endcase
    end
  end

  dpa_bins #(
    .TRACE_LEN (TRACE_LEN),
    .SAMPLE_W  (SAMPLE_W),
    .SUM_W     (SUM_W),
    .CNT_W     (CNT_W)
  ) u_bins (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (clr_run),
    .add_en  (state == ST_COMMIT),
    .add_bin (tgt_bin),
    .add_idx (c_idx),
    .add_val (stage_mem[c_idx]),
    .cnt_inc ((state == ST_COMMIT) && (c_idx == LAST_IDX)),
    .rd_idx  (r_idx),
    .rd_sum0 (rd_sum0),
    .rd_sum1 (rd_sum1),
    .cnt0    (cnt0),
    .cnt1    (cnt1)
  );

  dpa_bias #(
    .SUM_W  (SUM_W),
    .CNT_W  (CNT_W),
    .BIAS_W (BIAS_W)
  ) u_bias (
    .sum0 (rd_sum0),
    .sum1 (rd_sum1),
    .cnt0 (cnt0),
    .cnt1 (cnt1),
    .bias (m_data)
  );

endmodule

// File: rtl/dpa_partition_acc_chk.sv
module dpa_partition_acc_chk #(
  parameter int SAMPLE_W       = 8,
  parameter int TRACE_CAP_LOG2 = 16,
  localparam int CNT_W         = TRACE_CAP_LOG2 + 1,
  localparam int BIAS_W        = SAMPLE_W + TRACE_CAP_LOG2 + CNT_W + 2
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     clr_run,
  input logic                     s_valid,
  input logic                     s_ready,
  input logic                     s_last,
  input logic                     m_valid,
  input logic                     m_ready,
  input logic signed [BIAS_W-1:0] m_data,
  input logic                     m_last,
  input logic [CNT_W-1:0]         cnt0,
  input logic [CNT_W-1:0]         cnt1,
  input logic                     len_err
);

  a_r1_clear_zeroes: assert property (@(posedge clk) disable iff (!rst_n)
    clr_run |=> (cnt0 == '0 && cnt1 == '0 && !m_valid));

  a_r4_count_step0: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_run |=> (cnt0 == $past(cnt0) || cnt0 == $past(cnt0) + CNT_W'(1)));

  a_r4_count_step1: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_run |=> (cnt1 == $past(cnt1) || cnt1 == $past(cnt1) + CNT_W'(1)));

  a_r3_single_bin: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_run |=> !(cnt0 != $past(cnt0) && cnt1 != $past(cnt1)));

  a_r6_zero_bias: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && (cnt0 == '0 || cnt1 == '0)) |-> (m_data == '0));

  a_r7_err_follows_last: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |-> $past(s_valid && s_ready && s_last));

  a_r7_err_no_count: assert property (@(posedge clk) disable iff (!rst_n)
    len_err |-> ($stable(cnt0) && $stable(cnt1)));

  a_r8_busy_after_last: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready && s_last && !clr_run) |=> (len_err || !s_ready));

  a_r8_no_input_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid |-> !s_ready);

  a_r9_hold_on_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready && !clr_run) |=> (m_valid && $stable(m_data) && $stable(m_last)));

  a_r9_last_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
    m_last |-> m_valid);

endmodule

bind dpa_partition_acc dpa_partition_acc_chk #(
  .SAMPLE_W       (SAMPLE_W),
  .TRACE_CAP_LOG2 (TRACE_CAP_LOG2)
) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .clr_run (clr_run),
  .s_valid (s_valid),
  .s_ready (s_ready),
  .s_last  (s_last),
  .m_valid (m_valid),
  .m_ready (m_ready),
  .m_data  (m_data),
  .m_last  (m_last),
  .cnt0    (cnt0),
  .cnt1    (cnt1),
  .len_err (len_err)
);

// File: tb/dpa_partition_acc_tb.sv
`timescale 1ns/1ps
module dpa_partition_acc_tb;

  localparam int TL = 16;
  localparam int CW = 17;
  localparam int BW = 43;

  logic clk = 0;
  logic rst_n = 0;
  logic clr_run = 0;
  logic [31:0] ct_r = '0;
  logic [5:0] key_guess = '0;
  logic sel_mode = 0;
  logic [1:0] bit_pick = '0;
  logic s_valid = 0;
  logic s_ready;
  logic signed [7:0] s_data = '0;
  logic s_last = 0;
  logic rd_start = 0;
  logic m_valid;
  logic m_ready = 1;
  logic signed [BW-1:0] m_data;
  logic m_last;
  logic [CW-1:0] cnt0, cnt1;
  logic len_err;

  always #4 clk = ~clk;

  dpa_partition_acc u_dut (
    .clk(clk), .rst_n(rst_n), .clr_run(clr_run), .ct_r(ct_r), .key_guess(key_guess),
    .sel_mode(sel_mode), .bit_pick(bit_pick), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_last(s_last), .rd_start(rd_start), .m_valid(m_valid),
    .m_ready(m_ready), .m_data(m_data), .m_last(m_last), .cnt0(cnt0), .cnt1(cnt1),
    .len_err(len_err)
  );

  int n_cmp = 0;
  int n_bad = 0;
  longint m_s0 [TL];
  longint m_s1 [TL];
  longint m_c0 = 0;
  longint m_c1 = 0;
  longint exp_q [$];
  bit     last_q [$];
  int n_kept_nib = 0;
  int n_drop_nib = 0;

  int sb [4][16] = '{
    '{14, 4, 13, 1, 2, 15, 11, 8, 3, 10, 6, 12, 5, 9, 0, 7},
    '{0, 15, 7, 4, 14, 2, 13, 1, 10, 6, 12, 11, 9, 5, 3, 8},
    '{4, 1, 14, 8, 13, 6, 2, 11, 15, 12, 9, 7, 3, 10, 5, 0},
    '{15, 12, 8, 2, 4, 9, 1, 7, 5, 11, 3, 14, 10, 0, 6, 13}
  };

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int sel_of(input logic [31:0] ct, input logic [5:0] g);
    logic [5:0] x;
    x = g ^ {ct[0], ct[31:27]};
    return sb[{x[5], x[0]}][x[4:1]];
  endfunction

  // Scoreboard monitor: compares every accepted bias value.
  always @(negedge clk) begin
    if (rst_n && m_valid) begin
      chk(s_ready == 1'b0, "R8 s_ready during readout", longint'(s_ready), 0);
      if (m_ready) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R9 unexpected bias value", longint'(m_data), 0);
        end else begin
          longint e;
          bit el;
          e  = exp_q.pop_front();
          el = last_q.pop_front();
          chk(longint'(m_data) == e, "R5 bias value", longint'(m_data), e);
          chk(m_last == el, "R9 m_last", longint'(m_last), longint'(el));
        end
      end
    end
  end

  // Consumer stall pattern.
  int mr_cnt = 0;
  always @(posedge clk) begin
    #2;
    mr_cnt++;
    m_ready = (mr_cnt % 3) != 0;
  end

  task automatic beat(input logic signed [7:0] d, input bit last);
    s_valid = 1; s_data = d; s_last = last;
    @(negedge clk);
    while (!s_ready) @(negedge clk);
    @(posedge clk); #2;
    s_valid = 0; s_last = 0;
  endtask

  task automatic wait_ready();
    while (!s_ready) begin @(posedge clk); #2; end
  endtask

  task automatic send_trace(input logic [31:0] ct, input logic [5:0] g, input bit md,
                            input logic [1:0] bp, input int len, input int seed,
                            input logic [31:0] ct_late, input string tag);
    int v, smp[32];
    bit keep, b1;
    longint pc0, pc1;
    v = sel_of(ct, g);
    for (int i = 0; i < len; i++) begin
      smp[i] = ((seed * 37 + i * 53) % 181) - 90;
      if (i == 5 && v[0]) smp[i] += 25;
    end
    ct_r = ct; key_guess = g; sel_mode = md; bit_pick = bp;
    for (int i = 0; i < len; i++) begin
      beat(8'(smp[i]), i == len - 1);
      if (i == 0) begin ct_r = ct_late; key_guess = ~g; sel_mode = ~md; bit_pick = ~bp; end
    end
    chk(len_err == (len != TL), {tag, " R7 len_err"}, longint'(len_err), longint'(len != TL));
    chk(s_ready == (len != TL), {tag, " R8 s_ready after last"}, longint'(s_ready), longint'(len != TL));
    pc0 = m_c0; pc1 = m_c1;
    if (len == TL) begin
      if (!md) begin keep = 1; b1 = v[bp]; end
      else begin keep = (v == 15) || (v == 0); b1 = (v == 15); end
      if (md) begin if (keep) n_kept_nib++; else n_drop_nib++; end
      if (keep) begin
        for (int i = 0; i < TL; i++) begin
          if (b1) m_s1[i] += smp[i]; else m_s0[i] += smp[i];
        end
        if (b1) m_c1++; else m_c0++;
      end
    end
    wait_ready();
    chk(cnt0 == CW'(m_c0), {tag, " R2 cnt0"}, longint'(cnt0), m_c0);
    chk(cnt1 == CW'(m_c1), {tag, " R2 cnt1"}, longint'(cnt1), m_c1);
    if (len != TL || (md && !keep))
      chk(cnt0 == CW'(pc0) && cnt1 == CW'(pc1), {tag, " unchanged counts"}, longint'(cnt0 + cnt1), pc0 + pc1);
  endtask

  task automatic readout(input string tag);
    for (int i = 0; i < TL; i++) begin
      longint e;
      e = (m_c0 == 0 || m_c1 == 0) ? 0 : m_s1[i] * m_c0 - m_s0[i] * m_c1;
      exp_q.push_back(e);
      last_q.push_back(i == TL - 1);
    end
    wait_ready();
    rd_start = 1;
    @(posedge clk); #2;
    rd_start = 0;
    while (exp_q.size() != 0) begin @(posedge clk); #2; end
    @(posedge clk); #2;
    chk(s_ready == 1 && m_valid == 0, {tag, " R9 readout ends"}, longint'(m_valid), 0);
  endtask

  task automatic model_clear();
    for (int i = 0; i < TL; i++) begin m_s0[i] = 0; m_s1[i] = 0; end
    m_c0 = 0; m_c1 = 0;
  endtask

  initial begin
    #(8 * 190000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    model_clear();
    repeat (3) @(posedge clk);
    #2 rst_n = 1;
    @(posedge clk); #2;
    chk(cnt0 == 0 && cnt1 == 0, "R1 reset counts", longint'(cnt0 + cnt1), 0);
    chk(s_ready == 1 && m_valid == 0 && len_err == 0, "R1 reset handshake", longint'(s_ready), 1);
    readout("R1 R6 empty");

    // Single-bit mode, two different selection bits.
    for (int t = 0; t < 6; t++)
      send_trace(32'h1357_9BDF * (t + 3) + t, 6'h2A, 0, 2'd2, TL, t, 32'hFFFF_FFFF, "R3 single");
    readout("R3 R6 single");
    for (int t = 0; t < 6; t++)
      send_trace(32'h8421_0F0F ^ (t * 32'h0999_0001), 6'h2A, 0, 2'd0, TL, t + 20, 32'h0, "R3 bit0");
    readout("R5 mixed");

    // Settings changed after the first beat must not matter.
    send_trace(32'hA5A5_0001, 6'h13, 0, 2'd3, TL, 40, 32'h5A5A_FFFE, "R10 late change");

    // Wrong lengths.
    send_trace(32'h0000_0001, 6'h2A, 0, 2'd1, 10, 41, 32'h0, "R7 short");
    send_trace(32'h0000_0002, 6'h2A, 0, 2'd1, 20, 42, 32'h0, "R7 long");
    readout("R7 R5 after bad");

    // Nibble mode sweep.
    for (int t = 0; t < 32; t++)
      send_trace({t[4:0], 26'h0, t[5]}, 6'h05, 1, 2'd0, TL, t + 60, 32'h0, "R4 nibble");
    chk(n_kept_nib > 0 && n_drop_nib > 0, "R4 both outcomes seen", n_kept_nib, n_drop_nib);
    readout("R4 R5 nibble");

    // Clear a run.
    clr_run = 1;
    @(posedge clk); #2;
    clr_run = 0;
    model_clear();
    chk(cnt0 == 0 && cnt1 == 0, "R1 clear counts", longint'(cnt0 + cnt1), 0);
    readout("R1 R6 cleared");
    send_trace(32'h0F0F_1234, 6'h3C, 0, 2'd1, TL, 90, 32'h0, "R1 after clear");
    readout("R6 one bin");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule